// File: doc/BRIEF.md
# Indirect Redirection-Table Register Window

This block is the register file of an interrupt routing unit, reached by software through just two memory-mapped locations. A select register at offset 0x00 holds an 8-bit index. A data window at offset 0x10 reads or writes whatever register that index names. Behind the window sit a read-only version word, a 4-bit identification field and one 64-bit redirection entry per interrupt pin. Each entry is reached as two 32-bit halves.

Entry writes are merged into the stored entry. The delivery logic owns two status bits in each entry, and software writes cannot change them. An entry left in edge mode after a write has its remote-request bit cleared. The delivery logic updates those status bits through a side port. It learns of each rewritten entry, and of each change of mask bit, from one-cycle event pulses. Bus accesses are plain strobes: a write takes effect at the clock edge. A read returns its data on the cycle after the strobe, and there is no back-pressure in either direction.

Entry layout, by bit:

| Bits | Field |
|------|-------|
| 63:56 | destination |
| 16 | mask (1 = masked) |
| 15 | trigger mode (1 = level, 0 = edge) |
| 14 | remote-request (read-only to software) |
| 13 | polarity (stored only) |
| 12 | delivery status (read-only to software) |
| 11 | destination mode |
| 10:8 | delivery mode |
| 7:0 | vector |

Top module: `ioa_regwin`

## Requirements
- R1: After reset the select register and the ID read 0, and every entry reads 0x0001_0000 in its low half (mask bit 16 set) and 0 in its high half.
- R2: A write to offset 0x00 keeps only bits 7:0 of the (size-trimmed) data in the select register; a read of offset 0x00 returns it zero-extended.
- R3: Write data is trimmed by `wr_size`: 0 keeps bits 7:0, 1 keeps bits 15:0, 2 or 3 keeps all 32 bits; dropped bits count as 0.
- R4: With select 0x01 the window reads {8'h00, NUM_PINS-1, 8'h00, VERSION}; writes through it change nothing.
- R5: With select 0x00 or 0x02 the window reads the ID in bits 27:24, all other bits 0. Only a window write with select 0x00 loads the ID, from data bits 27:24.
- R6: With select s >= 0x10, the entry number is (s-0x10)>>1. s[0]=1 addresses bits 63:32 and s[0]=0 addresses bits 31:0, and a write replaces only that half.
- R7: A window read with select 0x03 to 0x0F, or with an entry number >= NUM_PINS, returns 0xFFFF_FFFF. A window write there changes no state.
- R8: Entry writes leave bit 14 (remote-request) and bit 12 (delivery status) at their previous values, whatever the data holds.
- R9: After an entry write whose resulting bit 15 is 0 (edge), bit 14 of that entry is 0.
- R10: Only offsets 0x00 and 0x10 of the 8-bit offset decode. Reads elsewhere return 0, and writes elsewhere are ignored.
- R11: `rd_vld` is high exactly on the cycle after each `rd_en`. `rd_data` then carries the value selected at the strobe, from state before any write in that same cycle.
- R12: On the cycle after every accepted entry write, `entry_evt` pulses with `evt_pin` set to the entry number. `mask_evt` pulses in the same cycle when the write flipped bit 16, and `evt_mask` gives the new mask.
- R13: A `stat_vld` strobe loads bit 14 from `stat_rirr` and bit 12 from `stat_dstat` of entry `stat_pin`. It does nothing when the pin is >= NUM_PINS, or when an entry write hits the same pin in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset inside the region; bits 7:0 decode |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write width: 0 byte, 1 halfword, 2/3 word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| stat_vld | input | 1 | Status update strobe from delivery logic |
| stat_pin | input | PIN_W | Entry the status update targets |
| stat_rirr | input | 1 | New remote-request value |
| stat_dstat | input | 1 | New delivery-status value |
| entry_evt | output | 1 | Pulse: an entry was rewritten |
| mask_evt | output | 1 | Pulse: the rewrite changed the mask bit |
| evt_pin | output | PIN_W | Entry number of the last rewrite |
| evt_mask | output | 1 | Mask value after the last rewrite |

## Verification
Every result in this block lands one clock after its cause. Read data and `rd_vld` come one edge after `rd_en`. Event pulses come one edge after the entry write. State written by a bus write or a status strobe is visible to a read strobe issued on the very next cycle. The bench drives all inputs on the falling edge and keeps a behavioural model that works out these next-cycle values ahead of the rising edge. It compares every output one time unit after each rising edge, and checks data and event fields only while their strobe is expected high.

// File: rtl/ioa_pkg.sv
package ioa_pkg;
  // region offsets (low 8 bits of the bus address)
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  // entry bit positions the block itself interprets
  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    K_ID  = 3'd0,
    K_VER = 3'd1,
    K_ARB = 3'd2,
    K_ENT = 3'd3,
    K_BAD = 3'd4
  } reg_kind_e;

  function automatic logic [31:0] trim_data(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/ioa_decode.sv
module ioa_decode #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic [7:0]          sel,
  output ioa_pkg::reg_kind_e  kind,
  output logic [PIN_W-1:0]    idx,
  output logic                hi
);
  import ioa_pkg::*;
  localparam logic [6:0] NP7 = 7'(NUM_PINS);

  logic [6:0] ent;

  always_comb begin
    ent = sel[7:1] - 7'd8;
    hi  = sel[0];
    idx = PIN_W'(ent);
    if (sel == 8'h00)      kind = K_ID;
    else if (sel == 8'h01) kind = K_VER;
    else if (sel == 8'h02) kind = K_ARB;
    else if (sel < 8'h10)  kind = K_BAD;
    else if (ent >= NP7)   kind = K_BAD;
    else                   kind = K_ENT;
  end
endmodule

// File: rtl/ioa_entry_bank.sv
module ioa_entry_bank #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [PIN_W-1:0] idx,
  input  logic             hi,
  input  logic [31:0]      wr_data,
  input  logic             st_vld,
  input  logic [PIN_W-1:0] st_pin,
  input  logic             st_rirr,
  input  logic             st_dstat,
  output logic [31:0]      rd_half,
  output logic             old_mask,
  output logic             new_mask
);
  import ioa_pkg::*;
  localparam int SLOTS = 1 << PIN_W;

  logic [63:0] ent_q [SLOTS];
  logic [63:0] cur;
  logic [63:0] merged;

  always_comb begin
    cur    = ent_q[idx];
    merged = cur;
    if (hi) merged[63:32] = wr_data;
    else    merged[31:0]  = wr_data;
    merged[B_RIRR]  = cur[B_RIRR];
    merged[B_DSTAT] = cur[B_DSTAT];
    if (!merged[B_TRIG]) merged[B_RIRR] = 1'b0;
  end

  assign old_mask = cur[B_MASK];
  assign new_mask = merged[B_MASK];
  assign rd_half  = hi ? ent_q[idx][63:32] : ent_q[idx][31:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_PINS) begin : g_reg
      logic [63:0] slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slot_q <= ENT_RESET;
        end else if (wr_vld && idx == PIN_W'(g)) begin
          slot_q <= merged;
        end else if (st_vld && st_pin == PIN_W'(g)) begin
          slot_q[B_RIRR]  <= st_rirr;
          slot_q[B_DSTAT] <= st_dstat;
        end
      end
      assign ent_q[g] = slot_q;
    end else begin : g_pad
      assign ent_q[g] = '1;
    end
  end
endmodule

// File: rtl/ioa_regwin.sv
module ioa_regwin #(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        PIN_W    = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic [31:0]       rd_data,
  input  logic              stat_vld,
  input  logic [PIN_W-1:0]  stat_pin,
  input  logic              stat_rirr,
  input  logic              stat_dstat,
  output logic              entry_evt,
  output logic              mask_evt,
  output logic [PIN_W-1:0]  evt_pin,
  output logic              evt_mask
);
  import ioa_pkg::*;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [7:0]       ofs;
  logic [31:0]      wdat;
  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  reg_kind_e        kind;
  logic [PIN_W-1:0] idx;
  logic             hi;
  logic             win_wr;
  logic             ent_we;
  logic [31:0]      ent_half;
  logic             old_mask, new_mask;
  logic [31:0]      rd_next;

  assign ofs    = bus_addr[7:0];
  assign wdat   = trim_data(wr_size, wr_data);
  assign win_wr = wr_en && (ofs == OFS_WIN);
  assign ent_we = win_wr && (kind == K_ENT);

  ioa_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
    .sel (sel_q),
    .kind(kind),
    .idx (idx),
    .hi  (hi)
  );

  ioa_entry_bank #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (ent_we),
    .idx     (idx),
    .hi      (hi),
    .wr_data (wdat),
    .st_vld  (stat_vld),
    .st_pin  (stat_pin),
    .st_rirr (stat_rirr),
    .st_dstat(stat_dstat),
    .rd_half (ent_half),
    .old_mask(old_mask),
    .new_mask(new_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
    end else begin
      if (wr_en && ofs == OFS_SEL) sel_q <= wdat[7:0];
      if (win_wr && kind == K_ID)  id_q  <= wdat[27:24];
    end
  end

  always_comb begin
    rd_next = 32'h0;
    if (ofs == OFS_SEL) begin
      rd_next = {24'h0, sel_q};
    end else if (ofs == OFS_WIN) begin
      case (kind)
        K_ID, K_ARB: rd_next = {4'h0, id_q, 24'h0};
        K_VER:       rd_next = VER_WORD;
        K_ENT:       rd_next = ent_half;
        default:     rd_next = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld    <= 1'b0;
      rd_data   <= 32'h0;
      entry_evt <= 1'b0;
      mask_evt  <= 1'b0;
      evt_pin   <= '0;
      evt_mask  <= 1'b1;
    end else begin
      rd_vld    <= rd_en;
      entry_evt <= ent_we;
      mask_evt  <= ent_we && (old_mask != new_mask);
      if (rd_en) rd_data <= rd_next;
      if (ent_we) begin
        evt_pin  <= idx;
        evt_mask <= new_mask;
      end
    end
  end
endmodule

// File: rtl/ioa_regwin_chk.sv
module ioa_regwin_chk #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ofs,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        rd_en,
  input logic        rd_vld,
  input logic [31:0] rd_data,
  input logic [7:0]  sel_q,
  input logic        entry_evt,
  input logic        mask_evt
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  a_r11_rd_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  a_r11_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs != 8'h00 && ofs != 8'h10) |=> rd_data == 32'h0);
  a_r7_low_sel_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == 8'h10 && sel_q >= 8'h03 && sel_q < 8'h10) |=> rd_data == 32'hFFFF_FFFF);
  a_r4_version_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == 8'h10 && sel_q == 8'h01) |=> rd_data == VER_WORD);
  a_r2_sel_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == 8'h00) |=> sel_q == $past(wr_data[7:0]));
  a_r12_mask_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> entry_evt);
  a_r12_evt_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |-> $past(wr_en && ofs == 8'h10));
endmodule

bind ioa_regwin ioa_regwin_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ofs      (bus_addr[7:0]),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_vld   (rd_vld),
  .rd_data  (rd_data),
  .sel_q    (sel_q),
  .entry_evt(entry_evt),
  .mask_evt (mask_evt)
);

// File: tb/tb_ioa_regwin.sv
module tb_ioa_regwin;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam logic [7:0] VER = 8'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd2;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_vld;
  logic [31:0] rd_data;
  logic        stat_vld = 1'b0;
  logic [4:0]  stat_pin = '0;
  logic        stat_rirr = 1'b0;
  logic        stat_dstat = 1'b0;
  logic        entry_evt, mask_evt, evt_mask;
  logic [4:0]  evt_pin;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [63:0] m_ent [NP];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        x_rvld, x_eevt, x_mevt, x_emask;
  logic [31:0] x_rdata;
  logic [4:0]  x_epin;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioa_regwin dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .wr_size(wr_size),
    .wr_data(wr_data), .rd_en(rd_en), .rd_vld(rd_vld), .rd_data(rd_data),
    .stat_vld(stat_vld), .stat_pin(stat_pin), .stat_rirr(stat_rirr), .stat_dstat(stat_dstat),
    .entry_evt(entry_evt), .mask_evt(mask_evt), .evt_pin(evt_pin), .evt_mask(evt_mask)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int n;
    if (a == 8'h00) return {24'h0, m_sel};
    if (a != 8'h10) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
    if (m_sel < 8'h10) return 32'hFFFF_FFFF;
    n = (int'(m_sel) - 16) / 2;
    if (n >= NP) return 32'hFFFF_FFFF;
    return m_sel[0] ? m_ent[n][63:32] : m_ent[n][31:0];
  endfunction

  // one clock: drive at negedge, predict, then compare after posedge
  task automatic step(input logic we, input logic re, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic sv, input logic [4:0] sp,
                      input logic sr, input logic sd, input string req);
    logic [31:0] td;
    logic [63:0] nv;
    int n;
    int wpin;
    @(negedge clk);
    wr_en = we; rd_en = re; bus_addr = a; wr_size = sz; wr_data = d;
    stat_vld = sv; stat_pin = sp; stat_rirr = sr; stat_dstat = sd;
    td = (sz == 2'd0) ? {24'h0, d[7:0]} : (sz == 2'd1) ? {16'h0, d[15:0]} : d;
    x_rvld = re;
    if (re) x_rdata = m_read(a);
    x_eevt = 1'b0; x_mevt = 1'b0;
    wpin = -1;
    if (we && a == 8'h00) m_sel = td[7:0];
    else if (we && a == 8'h10) begin
      if (m_sel == 8'h00) m_id = td[27:24];
      else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < NP) begin
        n = (int'(m_sel) - 16) / 2;
        wpin = n;
        nv = m_ent[n];
        if (m_sel[0]) nv[63:32] = td; else nv[31:0] = td;
        nv[14] = m_ent[n][14];
        nv[12] = m_ent[n][12];
        if (nv[15] == 1'b0) nv[14] = 1'b0;
        x_eevt = 1'b1;
        x_mevt = (nv[16] != m_ent[n][16]);
        x_epin = 5'(n);
        x_emask = nv[16];
        m_ent[n] = nv;
      end
    end
    if (sv && int'(sp) < NP && int'(sp) != wpin) begin
      m_ent[sp][14] = sr;
      m_ent[sp][12] = sd;
    end
    @(posedge clk);
    #1;
    chk(req, "rd_vld", {31'h0, rd_vld}, {31'h0, x_rvld});
    if (x_rvld) chk(req, "rd_data", rd_data, x_rdata);
    chk(req, "entry_evt", {31'h0, entry_evt}, {31'h0, x_eevt});
    chk(req, "mask_evt", {31'h0, mask_evt}, {31'h0, x_mevt});
    if (x_eevt) begin
      chk(req, "evt_pin", {27'h0, evt_pin}, {27'h0, x_epin});
      chk(req, "evt_mask", {31'h0, evt_mask}, {31'h0, x_emask});
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d, input string req);
    step(1'b1, 1'b0, a, sz, d, 1'b0, 5'd0, 1'b0, 1'b0, req);
  endtask
  task automatic rd(input logic [7:0] a, input string req);
    step(1'b0, 1'b1, a, 2'd2, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, req);
  endtask
  task automatic st(input logic [4:0] p, input logic r, input logic s, input string req);
    step(1'b0, 1'b0, 8'h00, 2'd2, 32'h0, 1'b1, p, r, s, req);
  endtask
  task automatic rd_ent(input logic [7:0] s, input string req);
    wr(8'h00, 2'd2, {24'h0, s}, req);
    rd(8'h10, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] lfsr;
    for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    m_sel = 8'h00; m_id = 4'h0;
    x_rvld = 1'b0; x_rdata = '0; x_eevt = 1'b0; x_mevt = 1'b0; x_emask = 1'b1; x_epin = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, "R1");
    rd(8'h10, "R1");
    rd_ent(8'h10, "R1");
    rd_ent(8'h11, "R1");
    rd_ent(8'h3E, "R1");
    chk("R1", "pin23 low at reset", x_rdata, 32'h0001_0000);

    // R2 select keeps low byte
    wr(8'h00, 2'd2, 32'h1234_56A5, "R2");
    rd(8'h00, "R2");
    chk("R2", "select value", rd_data, 32'h0000_00A5);

    // R3 write sizes, R12 mask flip event
    wr(8'h00, 2'd2, 32'h10, "R3");
    wr(8'h10, 2'd0, 32'hFFFF_FF33, "R3 R12");
    rd(8'h10, "R3");
    chk("R3", "byte write", rd_data, 32'h0000_0033);
    wr(8'h10, 2'd1, 32'hABCD_1234, "R3");
    rd(8'h10, "R3");
    wr(8'h10, 2'd3, 32'h0001_0042, "R3 R12");
    rd(8'h10, "R3");

    // R4 version
    wr(8'h00, 2'd2, 32'h01, "R4");
    rd(8'h10, "R4");
    chk("R4", "version", rd_data, {8'h00, 8'd23, 8'h00, VER});
    wr(8'h10, 2'd2, 32'hFFFF_FFFF, "R4");
    rd(8'h10, "R4");

    // R5 identification
    wr(8'h00, 2'd2, 32'h00, "R5");
    wr(8'h10, 2'd2, 32'hFA00_0000, "R5");
    rd(8'h10, "R5");
    chk("R5", "id read", rd_data, 32'h0A00_0000);
    wr(8'h00, 2'd2, 32'h02, "R5");
    rd(8'h10, "R5");
    wr(8'h10, 2'd2, 32'h0300_0000, "R5");
    rd_ent(8'h00, "R5");
    chk("R5", "arb write ignored", rd_data, 32'h0A00_0000);

    // R6 halves
    wr(8'h00, 2'd2, 32'h13, "R6");
    wr(8'h10, 2'd2, 32'hDEAD_BEEF, "R6");
    rd(8'h10, "R6");
    rd_ent(8'h12, "R6");
    chk("R6", "low half untouched", rd_data, 32'h0001_0000);

    // R7 out of range
    rd_ent(8'h40, "R7");
    wr(8'h10, 2'd2, 32'h0, "R7");
    rd(8'h10, "R7");
    chk("R7", "pin 24", rd_data, 32'hFFFF_FFFF);
    rd_ent(8'h05, "R7");
    wr(8'h10, 2'd2, 32'h0, "R7");
    rd_ent(8'hFF, "R7");
    rd_ent(8'h00, "R7");

    // R13 status port, R8 preservation
    st(5'd2, 1'b1, 1'b1, "R13");
    rd_ent(8'h14, "R13");
    chk("R13", "status loaded", rd_data, 32'h0001_5000);
    wr(8'h10, 2'd2, 32'h0000_8000, "R8");
    rd(8'h10, "R8");
    chk("R8", "level keeps rirr", rd_data, 32'h0000_D000);
    // R9 edge clears remote-request, delivery status kept
    wr(8'h10, 2'd2, 32'h0000_0020, "R9");
    rd(8'h10, "R9");
    chk("R9", "edge clears rirr", rd_data, 32'h0000_1020);
    wr(8'h00, 2'd2, 32'h16, "R8");
    wr(8'h10, 2'd2, 32'h0000_5000, "R8");
    rd(8'h10, "R8");
    chk("R8", "data cannot set status", rd_data, 32'h0);
    // upper-half write keeps level rirr
    st(5'd3, 1'b1, 1'b0, "R13");
    wr(8'h10, 2'd2, 32'h0000_8000, "R9");
    wr(8'h00, 2'd2, 32'h17, "R9");
    wr(8'h10, 2'd2, 32'h5500_0000, "R9");
    rd_ent(8'h16, "R9");
    chk("R9", "level rirr after hi write", rd_data, 32'h0000_C000);
    st(5'd30, 1'b1, 1'b1, "R13");
    step(1'b1, 1'b0, 8'h10, 2'd2, 32'h0000_0000, 1'b1, 5'd3, 1'b1, 1'b1, "R13");
    rd(8'h10, "R13");
    chk("R13", "write beats status", rd_data, 32'h0);

    // R10 unmapped offsets
    wr(8'h04, 2'd2, 32'h0000_0077, "R10");
    wr(8'h20, 2'd2, 32'h0000_0077, "R10");
    rd(8'h04, "R10");
    chk("R10", "offset 4", rd_data, 32'h0);
    rd(8'h00, "R10");
    chk("R10", "select unchanged", rd_data, 32'h0000_0016);

    // R11 back-to-back reads
    rd(8'h00, "R11");
    rd(8'h10, "R11");
    step(1'b0, 1'b0, 8'h10, 2'd2, 32'h0, 1'b0, 5'd0, 1'b0, 1'b0, "R11");

    // mixed traffic against the model
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      case (lfsr[31:29])
        3'd0, 3'd1: wr(8'h00, 2'd2, {24'h0, 2'b00, lfsr[5:0]} + 32'h10, "R6");
        3'd2: wr(8'h10, lfsr[28:27], {lfsr[26:0], lfsr[4:0]}, "R12");
        3'd3: st(lfsr[4:0], lfsr[5], lfsr[6], "R13");
        3'd4: wr(8'h00, 2'd0, {24'h0, lfsr[7:0]}, "R7");
        default: begin
          a = lfsr[8] ? 8'h10 : (lfsr[9] ? 8'h00 : {4'h0, lfsr[13:10]});
          rd(a, "R11");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule